// File: doc/BRIEF.md
# Program/Erase Completion Status Generator

This block sits in the read-data path of a flash bank model. When the host starts a word program or an erase, the block holds a busy flag for a configurable number of clock cycles, standing in for the internally timed operation. While that interval runs, any read returns two status bits that polling software can watch, in place of array data. One is a polarity bit: during a program it shows the inverse of bit 7 of the word being written, and during an erase it shows 0. The other is a toggle bit that changes value on every read access. All other bit positions still carry the external array read data.

When the counter runs out, reads carry the array word unmodified on every bit. For an erase, the external array then reads as all ones, so the polarity bit reads 1. The block's cycle counts for program, sector/block erase and whole-array erase are separate parameters. They can be set in the roughly 1 : 1250 : 5000 proportion of real devices, or shortened for simulation. Start pulses that arrive while an operation is running are ignored.

Top module: `flash_status_gen`

## Requirements
- R1: After a synchronous reset, busy is 0, rd_valid is 0 and rd_data is 0.
- R2: A one-cycle prog_start while idle raises busy on the next clock edge, and busy stays high for exactly PROG_CYC cycles.
- R3: A one-cycle erase_start while idle keeps busy high for SECT_CYC cycles when erase_whole is 0 and for CHIP_CYC cycles when erase_whole is 1.
- R4: During a program, bit 7 of every status read equals the inverse of bit 7 of prog_data as captured with the start pulse.
- R5: During an erase, bit 7 of every status read is 0. After completion, reads return the all-ones array word, so bit 7 reads 1.
- R6: Bit 6 of the first read after a start is 1 and inverts on each later read of the same operation. Cycles without a read leave it unchanged. Every accepted start reloads it.
- R7: A read (rd_en high at a clock edge) sets rd_valid and rd_data on that edge. rd_data bits other than 7 and 6 always equal array_data. When idle, all 16 bits equal array_data.
- R8: A read on the final busy cycle, which is the edge at which busy falls, returns true array data on all bits.
- R9: prog_start or erase_start asserted while busy is ignored: neither the remaining duration nor the operation kind changes.
- R10: If prog_start and erase_start arrive together while idle, the program is taken.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| prog_start | input | 1 | One-cycle pulse starting a word program |
| erase_start | input | 1 | One-cycle pulse starting an erase |
| erase_whole | input | 1 | With erase_start: 1 selects whole-array erase, 0 selects sector/block erase |
| prog_data | input | DW | Word being programmed, captured with prog_start |
| rd_en | input | 1 | Read access strobe |
| array_data | input | DW | Read data from the external array |
| busy | output | 1 | High while an operation runs |
| rd_valid | output | 1 | rd_data holds the result of the read issued on the previous edge |
| rd_data | output | DW | Registered read data with status bits during busy |

## Verification
The assertions assume that start requests are single-cycle pulses and that array_data is stable for the cycle in which rd_en is high. They also assume that, after an erase, the external array reports all ones. The bench changes inputs only after a clock edge has settled and holds them across the next edge. After every erase it switches array_data to 16'hFFFF, and it never expects a start pulse to be honoured while busy is high.

// File: rtl/fsg_pkg.sv
package fsg_pkg;
  typedef enum logic [1:0] {
    OP_IDLE = 2'd0,
    OP_PROG = 2'd1,
    OP_SECT = 2'd2,
    OP_CHIP = 2'd3
  } op_e;

  localparam int POLL_POS = 7;
  localparam int TGL_POS  = 6;
endpackage

// File: rtl/fsg_op_timer.sv
module fsg_op_timer
  import fsg_pkg::*;
#(
  parameter int DW       = 16,
  parameter int PROG_CYC = 16,
  parameter int SECT_CYC = 40,
  parameter int CHIP_CYC = 96
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          prog_start,
  input  logic          erase_start,
  input  logic          erase_whole,
  input  logic [DW-1:0] prog_data,
  output logic          busy,
  output op_e           kind,
  output logic          poll_bit,
  output logic          finishing,
  output logic          start_acc
);
  localparam int MAXA = (PROG_CYC > SECT_CYC) ? PROG_CYC : SECT_CYC;
  localparam int MAXC = (MAXA > CHIP_CYC) ? MAXA : CHIP_CYC;
  localparam int CW   = $clog2(MAXC + 1);

  logic [CW-1:0] cnt;

  assign start_acc = !busy && (prog_start || erase_start);
  assign finishing = busy && (cnt == CW'(1));

  always_ff @(posedge clk) begin
    if (rst) begin
      busy     <= 1'b0;
      cnt      <= '0;
      kind     <= OP_IDLE;
      poll_bit <= 1'b0;
    end else if (!busy) begin
      if (prog_start) begin
        busy     <= 1'b1;
        cnt      <= CW'(PROG_CYC);
        kind     <= OP_PROG;
        poll_bit <= ~prog_data[POLL_POS];
      end else if (erase_start) begin
        busy     <= 1'b1;
        cnt      <= erase_whole ? CW'(CHIP_CYC) : CW'(SECT_CYC);
        kind     <= erase_whole ? OP_CHIP : OP_SECT;
        poll_bit <= 1'b0;
      end
    end else begin
      cnt <= cnt - CW'(1);
      if (cnt == CW'(1)) begin
        busy <= 1'b0;
        kind <= OP_IDLE;
      end
    end
  end

  p_busy_cnt_r2: assert property (@(posedge clk) disable iff (rst)
    busy |-> cnt != '0);
  p_fall_zero_r3: assert property (@(posedge clk) disable iff (rst)
    $fell(busy) |-> cnt == '0);
  p_kind_hold_r9: assert property (@(posedge clk) disable iff (rst)
    (busy && $past(busy)) |-> ($stable(kind) && $stable(poll_bit)));
endmodule

// File: rtl/fsg_toggle.sv
module fsg_toggle (
  input  logic clk,
  input  logic rst,
  input  logic clear,
  input  logic step,
  output logic tgl
);
  always_ff @(posedge clk) begin
    if (rst || clear) tgl <= 1'b0;
    else if (step)    tgl <= ~tgl;
  end

  p_clear_known_r6: assert property (@(posedge clk) disable iff (rst)
    clear |=> !tgl);
  p_hold_r6: assert property (@(posedge clk) disable iff (rst)
    (!clear && !step) |=> $stable(tgl));
endmodule

// File: rtl/fsg_read_mux.sv
module fsg_read_mux
  import fsg_pkg::*;
#(
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          rd_en,
  input  logic          status_rd,
  input  logic          poll_bit,
  input  logic          tgl,
  input  logic [DW-1:0] array_data,
  output logic          rd_valid,
  output logic [DW-1:0] rd_data
);
  logic [DW-1:0] merged;

  always_comb begin
    merged = array_data;
    if (status_rd) begin
      merged[POLL_POS] = poll_bit;
      merged[TGL_POS]  = ~tgl;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_valid <= 1'b0;
      rd_data  <= '0;
    end else begin
      rd_valid <= rd_en;
      if (rd_en) rd_data <= merged;
    end
  end

  p_idle_pass_r7: assert property (@(posedge clk) disable iff (rst)
    (rd_valid && !$past(status_rd)) |-> rd_data == $past(array_data));
endmodule

// File: rtl/flash_status_gen.sv
module flash_status_gen
  import fsg_pkg::*;
#(
  parameter int DW       = 16,
  parameter int PROG_CYC = 16,
  parameter int SECT_CYC = 40,
  parameter int CHIP_CYC = 96
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          prog_start,
  input  logic          erase_start,
  input  logic          erase_whole,
  input  logic [DW-1:0] prog_data,
  input  logic          rd_en,
  input  logic [DW-1:0] array_data,
  output logic          busy,
  output logic          rd_valid,
  output logic [DW-1:0] rd_data
);
  op_e  kind;
  logic poll_bit, finishing, start_acc, tgl_q, status_rd;

  fsg_op_timer #(
    .DW(DW), .PROG_CYC(PROG_CYC), .SECT_CYC(SECT_CYC), .CHIP_CYC(CHIP_CYC)
  ) u_timer (
    .clk(clk), .rst(rst), .prog_start(prog_start), .erase_start(erase_start),
    .erase_whole(erase_whole), .prog_data(prog_data), .busy(busy),
    .kind(kind), .poll_bit(poll_bit), .finishing(finishing),
    .start_acc(start_acc)
  );

  assign status_rd = rd_en && busy && !finishing;

  fsg_toggle u_tgl (
    .clk(clk), .rst(rst), .clear(start_acc), .step(status_rd), .tgl(tgl_q)
  );

  fsg_read_mux #(.DW(DW)) u_mux (
    .clk(clk), .rst(rst), .rd_en(rd_en), .status_rd(status_rd),
    .poll_bit(poll_bit), .tgl(tgl_q), .array_data(array_data),
    .rd_valid(rd_valid), .rd_data(rd_data)
  );

  p_rose_tgl_r6: assert property (@(posedge clk) disable iff (rst)
    $rose(busy) |-> !tgl_q);
  p_done_true_r8: assert property (@(posedge clk) disable iff (rst)
    (rd_valid && $past(finishing)) |-> rd_data == $past(array_data));
  p_erase_poll_r5: assert property (@(posedge clk) disable iff (rst)
    (rd_valid && $past(status_rd) && $past(kind) != OP_PROG) |-> !rd_data[POLL_POS]);
  p_prog_poll_r4: assert property (@(posedge clk) disable iff (rst)
    (rd_valid && $past(status_rd) && $past(kind) == OP_PROG) |-> rd_data[POLL_POS] == $past(poll_bit));
endmodule

// File: tb/sim_flash_status_gen.sv
module sim_flash_status_gen;
  localparam int PROG_N = 16;
  localparam int SECT_N = 40;
  localparam int CHIP_N = 96;

  logic clk = 1'b0;
  logic rst, prog_start, erase_start, erase_whole, rd_en;
  logic [15:0] prog_data, array_data, rd_data;
  logic busy, rd_valid;
  int tests = 0, fails = 0, cyc = 0;

  always #2.5 clk = ~clk;

  flash_status_gen #(.DW(16), .PROG_CYC(PROG_N), .SECT_CYC(SECT_N), .CHIP_CYC(CHIP_N)) u0 (
    .clk(clk), .rst(rst), .prog_start(prog_start), .erase_start(erase_start),
    .erase_whole(erase_whole), .prog_data(prog_data), .rd_en(rd_en),
    .array_data(array_data), .busy(busy), .rd_valid(rd_valid), .rd_data(rd_data)
  );

  // kind(2: 1 prog, 2 sector erase, 3 whole erase), prog_data, array_data
  localparam logic [33:0] VEC [0:5] = '{
    {2'd1, 16'h0080, 16'h1234},
    {2'd1, 16'h0041, 16'hBEEF},
    {2'd2, 16'h0000, 16'h5A3C},
    {2'd3, 16'h0000, 16'hC3FF},
    {2'd1, 16'hFFFF, 16'h00FF},
    {2'd2, 16'h00FF, 16'hA5A5}
  };

  task automatic tick();
    @(posedge clk); #1;
  endtask

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic start(input logic p, input logic e, input logic w, input logic [15:0] d);
    prog_start = p; erase_start = e; erase_whole = w; prog_data = d;
    tick();
    prog_start = 0; erase_start = 0; erase_whole = 0;
  endtask

  task automatic rd();
    rd_en = 1; tick(); rd_en = 0;
  endtask

  task automatic measure(output int n);
    n = 0;
    while (busy && n < 2000) begin n++; tick(); end
  endtask

  function automatic logic [15:0] stat(input logic [1:0] k, input logic [15:0] pd,
                                       input logic [15:0] arr, input logic t);
    logic [15:0] v;
    v = arr;
    v[7] = (k == 2'd1) ? ~pd[7] : 1'b0;
    v[6] = t;
    return v;
  endfunction

  initial begin
    forever begin
      @(posedge clk); cyc++;
      if (cyc > 100000) begin
        fails++;
        $display("FAIL watchdog actual=%0d expected=%0d", cyc, 100000);
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
      end
    end
  end

  initial begin
    int n;
    logic [1:0] k;
    logic [15:0] pd, arr;
    rst = 1; prog_start = 0; erase_start = 0; erase_whole = 0; rd_en = 0;
    prog_data = 0; array_data = 16'h0000;
    tick(); tick(); rst = 0;
    // R1 reset state
    check("R1 busy", {15'd0, busy}, 16'd0);
    check("R1 rd_valid", {15'd0, rd_valid}, 16'd0);
    check("R1 rd_data", rd_data, 16'd0);

    // R7 idle read passes all bits
    array_data = 16'hA5C3; rd();
    check("R7 idle rd_valid", {15'd0, rd_valid}, 16'd1);
    check("R7 idle data", rd_data, 16'hA5C3);

    // R2 / R3 durations
    start(1, 0, 0, 16'h0); measure(n); check("R2 prog length", 16'(n), 16'(PROG_N));
    start(0, 1, 0, 16'h0); measure(n); check("R3 sector length", 16'(n), 16'(SECT_N));
    start(0, 1, 1, 16'h0); measure(n); check("R3 whole length", 16'(n), 16'(CHIP_N));

    // table walk: R4 R5 R6 R7
    foreach (VEC[i]) begin
      k = VEC[i][33:32]; pd = VEC[i][31:16]; arr = VEC[i][15:0];
      array_data = arr;
      start(k == 2'd1, k != 2'd1, k == 2'd3, pd);
      rd(); check("R4/R5/R6/R7 first status read", rd_data, stat(k, pd, arr, 1'b1));
      array_data = arr ^ 16'h0F30;
      rd(); check("R6/R7 second status read", rd_data, stat(k, pd, arr ^ 16'h0F30, 1'b0));
      tick();
      rd(); check("R6 no flip without read", rd_data, stat(k, pd, arr ^ 16'h0F30, 1'b1));
      measure(n);
      if (k != 2'd1) array_data = 16'hFFFF;
      rd();
      check("R4/R5 true data after completion", rd_data, (k != 2'd1) ? 16'hFFFF : (arr ^ 16'h0F30));
    end

    // R8 read on the completing cycle
    array_data = 16'h3C01;
    start(1, 0, 0, 16'h0080);
    for (int j = 0; j < PROG_N - 2; j++) tick();
    rd(); check("R8 read before last cycle is status", rd_data, stat(2'd1, 16'h0080, 16'h3C01, 1'b1));
    rd(); check("R8 completing read true data", rd_data, 16'h3C01);
    check("R8 busy fell", {15'd0, busy}, 16'd0);

    // R9 starts ignored while busy
    start(1, 0, 0, 16'h0000);
    tick();
    start(0, 1, 1, 16'h0080);
    rd(); check("R9 kind unchanged", rd_data, stat(2'd1, 16'h0000, 16'h3C01, 1'b1));
    measure(n); check("R9 duration unchanged", 16'(n), 16'(PROG_N - 3));

    // R10 simultaneous starts: program wins
    start(1, 1, 1, 16'h0000);
    rd(); check("R10 program taken", rd_data, stat(2'd1, 16'h0000, 16'h3C01, 1'b1));
    measure(n); check("R10 program length", 16'(n), 16'(PROG_N - 1));

    // R6 restart reloads toggle after an odd number of reads
    start(0, 1, 0, 16'h0);
    rd(); measure(n);
    start(0, 1, 0, 16'h0);
    rd(); check("R6 toggle reloaded on restart", rd_data, stat(2'd2, 16'h0, 16'h3C01, 1'b1));
    measure(n);

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule